// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block sits between device-side DMA masters and system memory. It turns a device address into a system address at 4 KiB page granularity. A programmable window, made of a base value and a mask, chooses which device addresses are translated. A matching request makes the block read one 64-bit entry from a flat table in memory. The entry address is computed from a programmable table pointer and the page number. The entry supplies the system page address or marks the page as absent.

Addresses outside the window, and all addresses while the window is disabled, bypass the table. They come back with only their in-page offset removed. Software programs the window and the table pointer through a small register port that accepts 32-bit and 64-bit accesses. A purge command register and a configuration register are also present. Both are stored and readable, and neither affects translation. The block handles one translation at a time, so responses return in request order.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, all five registers read as zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Registers sit at byte offsets 0x300 (window base), 0x308 (window mask), 0x310 (purge command), 0x318 (configuration) and 0x320 (table base). A 64-bit write (`reg_wide`=1) replaces the whole register. A 32-bit write with address bit 2 set replaces bits 63:32 and keeps bits 31:0. A 32-bit write with bit 2 clear replaces bits 31:0 and keeps bits 63:32. A 32-bit read returns the half chosen by bit 2 in `reg_rdata[31:0]`, with bits 63:32 zero. `reg_rdata` is valid in the cycle after `reg_rd_en`.
- R3: When bit 0 of the window base is 0, no request reads memory, whatever the mask holds.
- R4: Let page be the request address with bits 11:0 cleared. A request uses the table only if base bit 0 is 1 and (page AND mask) equals the base with bit 0 cleared. It then issues exactly one memory read at table_base + (page >> 12) * 8, with 64-bit wrap-around. A request that does not use the table issues no memory read.
- R5: If the fetched entry has bit 63 set, the response carries that entry with bit 63 and bits 11:0 cleared. `rsp_fault` is 0 and `rsp_perm` is 2'b11 (read and write).
- R6: If the fetched entry has bit 63 clear, the response has `rsp_fault`=1, `rsp_perm`=2'b00 and `rsp_addr`=0.
- R7: A table fetch that returns with `mem_rsp_err`=1 gives the same fault response as in R6, whatever the data.
- R8: A request that bypasses the table responds with `rsp_addr` equal to the page. Addresses at or below 0xFFFFFFFF are zero-extended and larger addresses pass through unchanged. `rsp_fault` is 0 and `rsp_perm` is 2'b11. `rsp_page_mask` is always 0xFFF.
- R9: A bypass responds one cycle after acceptance, and `req_ready` stays 1. A table request drops `req_ready` from acceptance until its response. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register byte address bits 11:2 |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| reg_rdata | output | 64 | Read data, valid the cycle after the read strobe |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Device-side address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 64 | Translated or bypassed page address |
| rsp_page_mask | output | 12 | In-page offset mask, always all ones |
| rsp_fault | output | 1 | Translation fault |
| rsp_perm | output | 2 | Access permission: 2'b11 read/write, 2'b00 none |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry, little-endian 64-bit word |
| mem_rsp_err | input | 1 | Read failed |

## Verification
Directed requests cover five cases: a disabled window with an all-zero mask that matches everything, addresses just inside and just outside the window, and bypass addresses below and above the 4 GiB line. Together these separate the enable flag, the mask comparison and the identity mapping. Valid, invalid and error-marked entries cover the three ways a table result can be formed. A seeded random stream mixes in-window, low and high addresses with varying memory latency and ready stalls. Each response is checked against a bench model, including the computed entry address and the number of memory reads. This catches page-number scaling errors and missing bypass decisions. Writes to the purge and configuration registers are mixed into the stream, so any influence they have on translation would appear.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

  localparam int unsigned DW = 64;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_WAIT  = 2'd2
  } wk_state_e;

  // Register slot order: window base, window mask, purge, config, table base.
  localparam int unsigned NREG       = 5;
  localparam int unsigned REG_FIRST  = 'h300;
  localparam int unsigned SLOT_BASE  = 0;
  localparam int unsigned SLOT_MASK  = 1;
  localparam int unsigned SLOT_TBASE = 4;

  function automatic logic [DW-1:0] merge_write(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v,
                                                input logic          wide,
                                                input logic          upper);
    if (wide)       return new_v;
    else if (upper) return {new_v[DW/2-1:0], old_v[DW/2-1:0]};
    else            return {old_v[DW-1:DW/2], new_v[DW/2-1:0]};
  endfunction

endpackage

// File: rtl/iopt_regs.sv
module iopt_regs
  import iopt_pkg::*;
#(
  parameter int unsigned REG_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:2] addr,
  input  logic              wide,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     win_base,
  output logic [DW-1:0]     win_mask,
  output logic [DW-1:0]     tbl_base
);

  localparam int unsigned SW = REG_AW - 3;

  logic [DW-1:0] regs_q [NREG];
  logic [NREG-1:0] slot_hit;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] rdata_q;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign slot_hit[g] = (addr[REG_AW-1:3] == SW'(REG_FIRST / 8 + g));
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++) begin
      if (slot_hit[i]) rd_word = regs_q[i];
    end
    if (!wide) begin
      rd_word = addr[2] ? {{(DW/2){1'b0}}, rd_word[DW-1:DW/2]}
                        : {{(DW/2){1'b0}}, rd_word[DW/2-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && slot_hit[i]) regs_q[i] <= merge_write(regs_q[i], wdata, wide, addr[2]);
      end
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign rdata    = rdata_q;
  assign win_base = regs_q[SLOT_BASE];
  assign win_mask = regs_q[SLOT_MASK];
  assign tbl_base = regs_q[SLOT_TBASE];

  AST_NARROW_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && addr[2] && slot_hit[SLOT_BASE]) |=> (win_base[DW/2-1:0] == $past(win_base[DW/2-1:0]))) // R2
    else $error("narrow upper write disturbed lower half");

  AST_NARROW_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && !addr[2] && slot_hit[SLOT_MASK]) |=> (win_mask[DW-1:DW/2] == $past(win_mask[DW-1:DW/2]))) // R2
    else $error("narrow lower write disturbed upper half");

endmodule

// File: rtl/iopt_window.sv
module iopt_window
  import iopt_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ENTRY_LOG2 = 3
) (
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] win_base,
  input  logic [DW-1:0] win_mask,
  input  logic [DW-1:0] tbl_base,
  output logic [DW-1:0] page_addr,
  output logic          use_table,
  output logic [DW-1:0] entry_addr
);

  localparam logic [DW-1:0] OFFS_MASK = {{(DW-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam logic [DW-1:0] EN_BIT    = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] page_num;

  assign page_addr  = req_addr & ~OFFS_MASK;
  assign page_num   = page_addr >> PAGE_SHIFT;
  assign use_table  = win_base[0] && ((page_addr & win_mask) == (win_base & ~EN_BIT));
  assign entry_addr = tbl_base + (page_num << ENTRY_LOG2);

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned VALID_BIT  = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          use_table,
  input  logic [DW-1:0] page_addr,
  input  logic [DW-1:0] entry_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_addr,
  output logic          rsp_fault,
  output logic [1:0]    rsp_perm
);

  localparam logic [DW-1:0] OFFS_MASK  = {{(DW-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam logic [DW-1:0] VALID_MASK = DW'(1) << VALID_BIT;

  wk_state_e     state_q;
  logic          mreq_q;
  logic [DW-1:0] maddr_q;
  logic          rv_q;
  logic [DW-1:0] raddr_q;
  logic          rfault_q;
  logic [1:0]    rperm_q;
  logic          entry_ok;

  assign entry_ok = !mem_rsp_err && ((mem_rsp_data & VALID_MASK) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= WK_IDLE;
      mreq_q   <= 1'b0;
      maddr_q  <= '0;
      rv_q     <= 1'b0;
      raddr_q  <= '0;
      rfault_q <= 1'b0;
      rperm_q  <= PERM_NONE;
    end else begin
      rv_q <= 1'b0;
      unique case (state_q)
        WK_IDLE: begin
          if (req_valid) begin
            if (use_table) begin
              mreq_q  <= 1'b1;
              maddr_q <= entry_addr;
              state_q <= WK_FETCH;
            end else begin
              rv_q     <= 1'b1;
              raddr_q  <= page_addr;
              rfault_q <= 1'b0;
              rperm_q  <= PERM_RW;
            end
          end
        end
        WK_FETCH: begin
          if (mem_req_ready) begin
            mreq_q  <= 1'b0;
            state_q <= WK_WAIT;
          end
        end
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            rv_q    <= 1'b1;
            state_q <= WK_IDLE;
            if (entry_ok) begin
              raddr_q  <= mem_rsp_data & ~VALID_MASK & ~OFFS_MASK;
              rfault_q <= 1'b0;
              rperm_q  <= PERM_RW;
            end else begin
              raddr_q  <= '0;
              rfault_q <= 1'b1;
              rperm_q  <= PERM_NONE;
            end
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WK_IDLE);
  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = maddr_q;
  assign rsp_valid     = rv_q;
  assign rsp_addr      = raddr_q;
  assign rsp_fault     = rfault_q;
  assign rsp_perm      = rperm_q;

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))) // R9
    else $error("table read request dropped or changed before acceptance");

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready) // R9
    else $error("request accepted while a fetch is outstanding");

  AST_RSP_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_addr[PAGE_SHIFT-1:0] == '0)) // R5
    else $error("response address carries in-page bits");

  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_perm == PERM_NONE && rsp_addr == '0)) // R6
    else $error("fault response grants access");

  AST_TABLE_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !req_ready) |-> 1'b0) // R9
    else $error("response while still busy");

endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
  import iopt_pkg::*;
#(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ENTRY_LOG2 = 3,
  parameter int unsigned VALID_BIT  = 63
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [REG_AW-1:2]     reg_addr,
  input  logic                  reg_wide,
  input  logic [63:0]           reg_wdata,
  output logic [63:0]           reg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [63:0]           req_addr,
  output logic                  rsp_valid,
  output logic [63:0]           rsp_addr,
  output logic [PAGE_SHIFT-1:0] rsp_page_mask,
  output logic                  rsp_fault,
  output logic [1:0]            rsp_perm,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [63:0]           mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [63:0]           mem_rsp_data,
  input  logic                  mem_rsp_err
);

  logic [DW-1:0] win_base, win_mask, tbl_base;
  logic [DW-1:0] page_addr, entry_addr;
  logic          use_table;

  iopt_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wide(reg_wide), .wdata(reg_wdata), .rdata(reg_rdata),
    .win_base(win_base), .win_mask(win_mask), .tbl_base(tbl_base)
  );

  iopt_window #(.PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LOG2(ENTRY_LOG2)) u_window (
    .req_addr(req_addr), .win_base(win_base), .win_mask(win_mask),
    .tbl_base(tbl_base), .page_addr(page_addr), .use_table(use_table),
    .entry_addr(entry_addr)
  );

  iopt_walker #(.PAGE_SHIFT(PAGE_SHIFT), .VALID_BIT(VALID_BIT)) u_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .use_table(use_table), .page_addr(page_addr), .entry_addr(entry_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .rsp_perm(rsp_perm)
  );

  assign rsp_page_mask = '1;

  AST_DISABLED_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !win_base[0]) |=> !mem_req_valid) // R3
    else $error("table read issued with window disabled");

endmodule

// File: tb/iopt_xlate_tb.sv
module iopt_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, reg_wide = 1'b0;
  logic [11:2] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_addr;
  logic [11:0] rsp_page_mask;
  logic [1:0]  rsp_perm;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0, n_bad = 0;
  int mem_reads = 0;
  logic [63:0] last_mem_addr = '0;
  bit inj_err = 0;
  bit done = 0;
  logic [63:0] sh [5];

  always #5 clk = ~clk;

  iopt_xlate u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wide(reg_wide), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_page_mask(rsp_page_mask), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  function automatic logic [63:0] ent(input logic [63:0] a);
    logic [63:0] p;
    p = a * 64'h9E37_79B9_7F4A_7C15;
    return {a[3] ^ a[7], p[62:12], 12'h5a5};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int pend = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = ent(last_mem_addr);
          mem_rsp_err   = inj_err;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready && pend == 0 && !mem_rsp_valid) begin
        mem_reads++;
        last_mem_addr = mem_req_addr;
        pend = 1 + ($urandom % 4);
      end
    end
  end

  task automatic wr(input int slot, input bit wide, input bit hi, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wide = wide;
    reg_addr = 10'((12'h300 + slot * 8 + (hi ? 4 : 0)) >> 2);
    reg_wdata = d;
    if (wide) sh[slot] = d;
    else if (hi) sh[slot] = {d[31:0], sh[slot][31:0]};
    else sh[slot] = {sh[slot][63:32], d[31:0]};
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input int slot, input bit wide, input bit hi, output logic [63:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_wide = wide;
    reg_addr = 10'((12'h300 + slot * 8 + (hi ? 4 : 0)) >> 2);
    @(negedge clk);
    reg_rd_en = 0;
    d = reg_rdata;
  endtask

  task automatic xlate(input logic [63:0] a, input bit err, input string tag);
    logic [63:0] page, ea, e, exp_addr;
    bit hit, exp_fault, got, busy;
    logic [1:0] exp_perm;
    int reads0;
    page = a & ~64'hfff;
    hit = sh[0][0] && ((page & sh[1]) == (sh[0] & ~64'h1));
    ea = sh[4] + ((page >> 12) << 3);
    e = ent(ea);
    if (!hit) begin exp_addr = page; exp_fault = 0; exp_perm = 2'b11; end
    else if (err || !e[63]) begin exp_addr = 0; exp_fault = 1; exp_perm = 2'b00; end
    else begin exp_addr = e & ~(64'h1 << 63) & ~64'hfff; exp_fault = 0; exp_perm = 2'b11; end
    inj_err = err;
    reads0 = mem_reads;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    busy = !req_ready;
    got = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      if (rsp_valid) got = 1;
      else @(negedge clk);
    end
    chk(got, {tag, " R9 response arrives"}, 64'(got), 64'd1);
    chk(busy == hit, {tag, " R9 ready during lookup"}, 64'(busy), 64'(hit));
    chk(rsp_addr == exp_addr, {tag, " R5/R6/R8 address"}, rsp_addr, exp_addr);
    chk(rsp_fault == exp_fault && rsp_perm == exp_perm, {tag, " R6/R7 fault+perm"},
        {rsp_fault, rsp_perm}, {exp_fault, exp_perm});
    chk(rsp_page_mask == 12'hfff, {tag, " R8 page mask"}, 64'(rsp_page_mask), 64'hfff);
    chk(mem_reads - reads0 == (hit ? 1 : 0), {tag, " R3/R4 read count"},
        64'(mem_reads - reads0), 64'(hit));
    if (hit) chk(last_mem_addr == ea, {tag, " R4 entry address"}, last_mem_addr, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 5; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1 && rsp_valid == 0, "R1 ports after reset", {req_ready, rsp_valid}, 2'b10);
    for (int i = 0; i < 5; i++) begin
      rd(i, 1, 0, d);
      chk(d == 0, "R1 register zero", d, 0);
    end
    // R2 narrow and wide accesses
    wr(0, 1, 0, 64'h1111_2222_3333_4444);
    wr(0, 0, 1, 64'hdead_beef_aaaa_5555);
    rd(0, 1, 0, d); chk(d == 64'haaaa_5555_3333_4444, "R2 upper-half write", d, 64'haaaa_5555_3333_4444);
    wr(0, 0, 0, 64'hffff_ffff_0bad_f00d);
    rd(0, 1, 0, d); chk(d == 64'haaaa_5555_0bad_f00d, "R2 lower-half write", d, 64'haaaa_5555_0bad_f00d);
    rd(0, 0, 1, d); chk(d == 64'h0000_0000_aaaa_5555, "R2 narrow upper read", d, 64'haaaa_5555);
    rd(0, 0, 0, d); chk(d == 64'h0000_0000_0bad_f00d, "R2 narrow lower read", d, 64'h0bad_f00d);
    wr(3, 1, 0, 64'h0123_4567_89ab_cdef);
    rd(3, 1, 0, d); chk(d == 64'h0123_4567_89ab_cdef, "R2 config register", d, 64'h0123_4567_89ab_cdef);
    // R3 window disabled, mask zero matches everything
    wr(0, 1, 0, 64'h0); wr(1, 1, 0, 64'h0); wr(4, 1, 0, 64'h0010_0000);
    xlate(64'h0000_0000_8000_1234, 0, "R3 disabled");
    xlate(64'h0000_0012_3456_7fff, 0, "R3 disabled high");
    // enable window 0x8000_0000 .. 0x8fff_ffff
    wr(0, 1, 0, 64'h8000_0001); wr(1, 1, 0, 64'hffff_ffff_f000_0000);
    xlate(64'h0000_0000_8000_0abc, 0, "R4 first page");
    xlate(64'h0000_0000_8fff_ffff, 0, "R4 last page");
    xlate(64'h0000_0000_8000_1008, 0, "R5 valid/R6 invalid a");
    xlate(64'h0000_0000_8000_3008, 0, "R5 valid/R6 invalid b");
    xlate(64'h0000_0000_8000_2000, 1, "R7 read error");
    xlate(64'h0000_0000_9000_0000, 0, "R8 just above window");
    xlate(64'h0000_0000_7fff_ffff, 0, "R8 just below window");
    xlate(64'h0000_0000_ffff_ffff, 0, "R8 top of 32-bit");
    xlate(64'hffff_ffff_8000_0123, 0, "R8 above 4G");
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [63:0] a;
      int kind;
      kind = $urandom % 3;
      if (kind == 0) a = {32'h0, 4'h8, 28'($urandom)};
      else if (kind == 1) a = {32'h0, 32'($urandom)};
      else a = {32'($urandom), 32'($urandom)};
      if (n % 40 == 7) wr(2, 1, 0, {32'($urandom), 32'($urandom)});
      if (n % 40 == 23) wr(3, 0, n[0], {32'($urandom), 32'($urandom)});
      if (n == 150) wr(4, 1, 0, 64'hffff_ffff_ffff_f000);
      xlate(a, ($urandom % 10) == 0, "random R4/R5");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule